// File: doc/BRIEF.md
# Serial EEPROM Slave over a Two-Wire Bus

This block is a two-wire (I2C) bus slave placed in front of a small on-chip byte array so that it behaves like a serial EEPROM. SCL and SDA are oversampled with the system clock through a short synchronizer. START and STOP are detected from the synchronized levels, and the slave shifts bits in on SCL rising edges and changes its own SDA drive only after SCL has fallen. SDA is open drain: the block has no data output, only an enable that pulls the line low.

A command opens with a select byte. Its upper nibble is fixed at 1010, the next three bits must equal three strap inputs, and the last bit chooses the direction. A write-direction command carries two address bytes, high one first, followed by data that fills one page with wrap-around inside the page. Random reads use a write-direction select with the address, then a repeated START and a read-direction select. A STOP that closes a write with data starts a programming interval of fixed length, during which the slave ignores START and so leaves its select unanswered. A write-protect input and a power-on hold input restrict what the bus can do.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) opens a command and a STOP (SDA rising while SCL is high) ends it; after a STOP the slave acknowledges no byte until the next START.
- R2: The slave acknowledges a select byte only when bits 7..4 are 1010 and bits 3..1 equal chip_en[2:0] (bit 3 = chip_en[2]). Bit 0 = 1 means read and 0 means write. After a select that does not match, the slave acknowledges nothing until the next START.
- R3: After a write select, the slave acknowledges two address bytes, high byte first. The pointer becomes the low ADDR_W bits of the 16-bit address, and the upper bits are ignored.
- R4: When wr_ctrl is low, each data byte is acknowledged and stored at the pointer. Only the low PAGE_W pointer bits then advance, wrapping inside the page.
- R5: When wr_ctrl is high, the select and address bytes are still acknowledged, but data bytes are not acknowledged, no location changes and no programming interval starts.
- R6: In read mode, the slave sends the byte at the pointer MSB first and increments the whole pointer after each byte, wrapping at the end of the array. It sends the next byte after a master acknowledge and releases SDA after a master non-acknowledge.
- R7: A STOP that ends a write with at least one stored data byte starts a programming interval of PROG_CYCLES clocks. During this interval a select is not acknowledged, and after it a select is acknowledged again.
- R8: While por_hold is high, the slave ignores all bus activity, never drives SDA and leaves the array unchanged.
- R9: SDA is only ever pulled low or released. The slave releases SDA during reset and changes its drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| por_hold | input | 1 | Power-on hold; while high the bus is ignored |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| chip_en | input | 3 | Strap value expected in select bits 3..1 |
| wr_ctrl | input | 1 | Write protect for the whole array when high |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except for START and STOP, and each SCL level lasts longer than the three-stage synchronizer delay. Under that assumption the slave never sees a false START or STOP from its own drive. The bench master holds every bus phase for six system clocks and changes SDA only in the SCL low phase. It drives inputs on falling system-clock edges and inserts the programming wait after each protected-free write, except where a busy select is probed on purpose. Random addresses, lengths, data and strap values come from a seeded generator.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W      = 7,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_hold,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] chip_en,
  input  logic       wr_ctrl,
  output logic       sda_drive_low
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [PAGE_W-1:0] PONE = 1;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AH, S_AL, S_WR, S_RD} st_t;

  st_t               state;
  logic [2:0]        scl_q, sda_q;
  logic [3:0]        bitcnt;
  logic [7:0]        sh, tx, ahi;
  logic [ADDR_W-1:0] ptr;
  logic              rw, mack, wrote, drv;
  logic [CNT_W-1:0]  prog_cnt;
  logic [7:0]        mem [DEPTH];

  wire start_c = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire rise    = scl_q[1] & ~scl_q[2];
  wire fall    = ~scl_q[1] & scl_q[2];
  wire busy    = prog_cnt != '0;
  wire sel_ok  = (sh[7:4] == 4'b1010) && (sh[3:1] == chip_en);
  wire [15:0] addr_full = {ahi, sh};

  assign sda_drive_low = drv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; sh <= '0; tx <= '0; ahi <= '0; ptr <= '0;
      rw <= 1'b0; mack <= 1'b0; wrote <= 1'b0; drv <= 1'b0; prog_cnt <= '0;
    end else if (por_hold) begin
      state <= S_IDLE; bitcnt <= '0; wrote <= 1'b0; drv <= 1'b0; prog_cnt <= '0;
    end else begin
      if (busy) prog_cnt <= prog_cnt - 1'b1;
      if (stop_c) begin
        state <= S_IDLE;
        drv   <= 1'b0;
        wrote <= 1'b0;
        if (wrote) prog_cnt <= CNT_W'(PROG_CYCLES);
      end else if (start_c && !busy) begin
        state  <= S_DEV;
        bitcnt <= '0;
        drv    <= 1'b0;
      end else if (state != S_IDLE) begin
        if (rise) begin
          if (bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
            if (state != S_RD) sh <= {sh[6:0], sda_q[1]};
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            mack   <= ~sda_q[1];
          end
        end else if (fall) begin
          if (state == S_RD) begin
            if (bitcnt == 4'd8) begin
              drv <= 1'b0;
              ptr <= ptr + 1'b1;
            end else if (bitcnt == 4'd9) begin
              if (mack) begin
                tx     <= mem[ptr];
                drv    <= ~mem[ptr][7];
                bitcnt <= '0;
              end else begin
                state <= S_IDLE;
                drv   <= 1'b0;
              end
            end else if (bitcnt != 4'd0) begin
              tx  <= {tx[6:0], 1'b0};
              drv <= ~tx[6];
            end
          end else if (bitcnt == 4'd8) begin
            case (state)
              S_DEV: if (sel_ok) begin drv <= 1'b1; rw <= sh[0]; end
                     else state <= S_IDLE;
              S_AH:  begin drv <= 1'b1; ahi <= sh; end
              S_AL:  begin drv <= 1'b1; ptr <= addr_full[ADDR_W-1:0]; end
              S_WR:  if (!wr_ctrl) begin
                       drv      <= 1'b1;
                       wrote    <= 1'b1;
                       mem[ptr] <= sh;
                       ptr      <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PONE};
                     end
              default: ;
            endcase
          end else if (bitcnt == 4'd9) begin
            drv    <= 1'b0;
            bitcnt <= '0;
            case (state)
              S_DEV: if (rw) begin
                       state <= S_RD;
                       tx    <= mem[ptr];
                       drv   <= ~mem[ptr][7];
                     end else state <= S_AH;
              S_AH:  state <= S_AL;
              S_AL:  state <= S_WR;
              default: ;
            endcase
          end
        end
      end
    end
  end

  a_r8_por_release: assert property (@(posedge clk) disable iff (!rst_n)
    por_hold |=> !sda_drive_low);

  a_r9_drive_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv) |-> !scl_q[1]);

  a_r7_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> state == S_IDLE);

  a_r5_protect_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && fall && bitcnt == 4'd8 && wr_ctrl && !por_hold) |=> !drv);

  a_r6_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9);
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int AW = 7, PW = 4, PROG = 300, Q = 6, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, por_hold, scl_m, m_low, wr_ctrl;
  logic [2:0] chip_en;
  logic sda_drive_low;
  wire  sda_bus = ~(m_low | sda_drive_low);

  logic [7:0] model [DEPTH];
  int checks = 0, errors = 0, viol = 0, por_drv = 0;
  logic last_drv = 1'b0;

  i2c_eeprom_slave #(.ADDR_W(AW), .PAGE_W(PW), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_hold(por_hold), .scl_i(scl_m), .sda_i(sda_bus),
    .chip_en(chip_en), .wr_ctrl(wr_ctrl), .sda_drive_low(sda_drive_low));

  always @(posedge clk) begin
    #1;
    if (scl_m && sda_drive_low != last_drv) viol++;
    if (por_hold && sda_drive_low) por_drv++;
    last_drv = sda_drive_low;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run;
  end

  function automatic int page_idx(input logic [15:0] a, input int i);
    int base = int'(a) & (DEPTH - 1) & ~((1 << PW) - 1);
    return base | ((int'(a) + i) & ((1 << PW) - 1));
  endfunction

  task automatic hq; repeat (Q) @(negedge clk); endtask

  task automatic bus_start;
    m_low = 1'b0; hq; scl_m = 1'b1; hq; m_low = 1'b1; hq; scl_m = 1'b0; hq;
  endtask

  task automatic bus_stop;
    m_low = 1'b1; hq; scl_m = 1'b1; hq; m_low = 1'b0; hq;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hq; scl_m = 1'b1; hq; hq; scl_m = 1'b0; hq;
    end
    m_low = 1'b0; hq; scl_m = 1'b1; hq; ack = ~sda_bus; hq; scl_m = 1'b0; hq;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hq; scl_m = 1'b1; hq; b[i] = sda_bus; hq; scl_m = 1'b0;
    end
    hq; m_low = give_ack; hq; scl_m = 1'b1; hq; hq; scl_m = 1'b0; hq; m_low = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input string req, input bit settle);
    bit k;
    logic [7:0] d;
    bus_start;
    send_byte({4'b1010, chip_en, 1'b0}, k); check(k, "R2 write select ack", k, 1);
    send_byte(a[15:8], k); check(k, "R3 high address ack", k, 1);
    send_byte(a[7:0], k);  check(k, "R3 low address ack", k, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, k);
      check(k == !wr_ctrl, req, k, !wr_ctrl);
      if (!wr_ctrl) model[page_idx(a, i)] = d;
    end
    bus_stop;
    if (settle && !wr_ctrl && n > 0) repeat (PROG + 10) @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string req);
    bit k;
    logic [7:0] b;
    bus_start;
    send_byte({4'b1010, chip_en, 1'b0}, k); check(k, "R2 dummy select ack", k, 1);
    send_byte(a[15:8], k); check(k, "R3 high address ack", k, 1);
    send_byte(a[7:0], k);  check(k, "R3 low address ack", k, 1);
    bus_start;
    send_byte({4'b1010, chip_en, 1'b1}, k); check(k, "R2 read select ack", k, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(b === model[(int'(a) + i) & (DEPTH - 1)], req, b, model[(int'(a) + i) & (DEPTH - 1)]);
    end
    check(sda_drive_low == 1'b0, "R6 release after master nack", sda_drive_low, 0);
    bus_stop;
  endtask

  initial begin
    bit k;
    logic [15:0] a;
    void'($urandom(32'd4242));
    rst_n = 1'b0; por_hold = 1'b0; scl_m = 1'b1; m_low = 1'b0; wr_ctrl = 1'b0; chip_en = 3'b101;
    repeat (5) @(negedge clk);
    check(sda_drive_low == 1'b0, "R9 released in reset", sda_drive_low, 0);
    rst_n = 1'b1; hq;

    for (int p = 0; p < DEPTH / (1 << PW); p++) do_write(16'(p << PW), 1 << PW, "R4 page fill data ack", 1'b1);
    do_read(16'h0000, DEPTH, "R6 sequential read of whole array");
    do_read(16'(DEPTH - 4), 8, "R6 read wraps at array end");

    do_write(16'h5A1E, 4, "R4 data ack near page end", 1'b1);
    do_read(16'h0010, 1 << PW, "R4 page wrap and R3 high bits ignored");

    wr_ctrl = 1'b1;
    do_write(16'h0020, 3, "R5 data not acked when protected", 1'b1);
    wr_ctrl = 1'b0;
    do_read(16'h0020, 3, "R5 protected data unchanged, no busy");

    bus_start;
    send_byte({4'b1010, chip_en ^ 3'b010, 1'b0}, k); check(!k, "R2 strap mismatch nack", k, 0);
    send_byte(8'h00, k); check(!k, "R2 ignored after mismatch", k, 0);
    bus_stop;
    bus_start;
    send_byte({4'b1011, chip_en, 1'b0}, k); check(!k, "R2 upper nibble mismatch nack", k, 0);
    bus_stop;
    chip_en = 3'b010;
    do_read(16'h0005, 2, "R2 new strap value accepted");

    bus_start;
    send_byte({4'b1010, chip_en, 1'b0}, k); check(k, "R1 select ack", k, 1);
    send_byte(8'h00, k); check(k, "R1 address ack", k, 1);
    bus_stop;
    send_byte(8'hA0, k); check(!k, "R1 no ack without START", k, 0);

    do_write(16'h0040, 1, "R7 data ack", 1'b0);
    bus_start;
    send_byte({4'b1010, chip_en, 1'b0}, k); check(!k, "R7 select nack while programming", k, 0);
    bus_stop;
    repeat (PROG) @(negedge clk);
    bus_start;
    send_byte({4'b1010, chip_en, 1'b0}, k); check(k, "R7 select ack after programming", k, 1);
    bus_stop;

    por_hold = 1'b1; hq;
    bus_start;
    send_byte({4'b1010, chip_en, 1'b0}, k); check(!k, "R8 select ignored in power-on hold", k, 0);
    send_byte(8'h00, k);
    send_byte(8'h50, k);
    send_byte(8'h77, k); check(!k, "R8 data ignored in power-on hold", k, 0);
    bus_stop;
    por_hold = 1'b0; hq;
    check(por_drv == 0, "R8 no drive in power-on hold", por_drv, 0);
    do_read(16'h0050, 1, "R8 array unchanged by held bus");

    for (int it = 0; it < 8; it++) begin
      chip_en = 3'($urandom);
      a = 16'($urandom);
      do_write(a, 1 + int'($urandom % 6), "R4 random write ack", 1'b1);
      do_read({a[15:PW], PW'(0)}, 1 << PW, "R6 random page readback");
    end

    check(viol == 0, "R9 drive changed while SCL high", viol, 0);
    finish_run;
  end
endmodule